// File: doc/BRIEF.md
# ADC Code Histogram Collector

This block measures how noisy a converter is by counting how often each output code appears. It sits on a valid/data sample stream. Every sample it accepts adds one to a counter in an on-chip memory, and the sample's code is the address of that counter. A saturating total of accepted samples is kept next to the bins.

A host starts a run with a start pulse, which first zeroes every bin and the total. The host can also set a number of warm-up conversions to throw away, because the first readings after setup can be outliers. Accumulation runs until a stop pulse. The host then reads each bin through a synchronous read port.

The increment path is a read, add and write pipeline that accepts one sample per clock. When a sample hits the same bin as the write that is still in flight, the in-flight value is forwarded, so no count is lost.

Top module: `adc_hist_collector`

## Requirements
- R1: After reset, `busy`, `accum` and `rd_valid` are low and `total` is zero.
- R2: A `start` pulse raises `busy` on the next clock for exactly 2^CODE_W cycles. During that time one bin per clock is written to zero. When `busy` falls, every bin and `total` read as zero.
- R3: The value on `warm_cnt` is captured at `start`. After the clear, that many valid conversions are discarded whatever their codes, and then `accum` rises. With a count of zero, `accum` rises as soon as `busy` falls.
- R4: While `accum` is high, a valid sample with a code from 0 to 2^CODE_W-1 adds exactly one to the bin whose address equals the code.
- R5: While accumulating, a valid sample whose code is greater than 2^CODE_W-1 changes neither any bin nor `total`.
- R6: One sample per clock is accepted. Any number of back-to-back or interleaved hits on the same bin are all counted.
- R7: A bin counter of CNT_W bits stops at all ones and does not wrap.
- R8: `total` counts accepted in-range samples, saturates at all ones, and otherwise steps by at most one per clock.
- R9: A read request with `rd_en` and `rd_addr` is served only while the block is stopped (neither clearing nor accumulating). `rd_valid` and that bin's count then appear one cycle later. A request while busy or accumulating leaves `rd_valid` low.
- R10: A `stop` pulse ends accumulation. Later samples change no bin and not `total`.
- R11: Samples that arrive while `busy` is high are ignored. They do not count toward the warm-up either.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse: clear all bins, then warm up and accumulate |
| stop | input | 1 | Pulse: end warm-up or accumulation |
| warm_cnt | input | WARM_W | Number of conversions to discard, captured at start |
| in_valid | input | 1 | Sample strobe |
| in_code | input | SAMPLE_W | Converter code |
| busy | output | 1 | Clear walk in progress |
| accum | output | 1 | Samples are being accumulated |
| total | output | TOT_W | Accepted sample count (saturating) |
| rd_en | input | 1 | Bin read request |
| rd_addr | input | CODE_W | Bin to read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | CNT_W | Count of the requested bin |

## Verification
Some rules are checked by the assertions on every cycle:
- The clear walk steps by one address per clock.
- Consecutive writes to the same bin differ by exactly one, or sit at saturation.
- No write leaves a bin at zero.
- `total` never jumps by more than one and holds still on out-of-range codes.
- `rd_valid` never appears while the block is clearing or accumulating.

The bench scenarios are needed for the rest. These are the exact bin contents after a full sweep of in-range and out-of-range codes, and the length of the warm-up discard. The bench also shows that samples during the clear or after stop are lost, and that a bin reaches saturation under long same-bin bursts.

// File: rtl/adc_hist_pkg.sv
package adc_hist_pkg;

   typedef enum logic [1:0] {
      HS_IDLE  = 2'd0,
      HS_CLEAR = 2'd1,
      HS_WARM  = 2'd2,
      HS_ACC   = 2'd3
   } hist_state_e;

endpackage

// File: rtl/adc_hist_ctrl.sv
module adc_hist_ctrl
   import adc_hist_pkg::*;
#(
   parameter int CODE_W = 10,
   parameter int WARM_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              stop,
   input  logic [WARM_W-1:0] warm_cnt,
   input  logic              in_valid,
   input  logic              in_range,
   output hist_state_e       state,
   output logic              clr_we,
   output logic [CODE_W-1:0] clr_addr,
   output logic              acc_fire
);

   localparam logic [CODE_W-1:0] LAST_ADDR = {CODE_W{1'b1}};

   logic [WARM_W-1:0] warm_left;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= HS_IDLE;
         clr_addr  <= '0;
         warm_left <= '0;
      end else if (start) begin
         state     <= HS_CLEAR;
         clr_addr  <= '0;
         warm_left <= warm_cnt;
      end else begin
         unique case (state)
            HS_CLEAR: begin
               clr_addr <= clr_addr + 1'b1;
               if (clr_addr == LAST_ADDR)
                  state <= (warm_left == '0) ? HS_ACC : HS_WARM;
            end
            HS_WARM: begin
               if (stop) begin
                  state <= HS_IDLE;
               end else if (in_valid) begin
                  warm_left <= warm_left - 1'b1;
                  if (warm_left == WARM_W'(1))
                     state <= HS_ACC;
               end
            end
            HS_ACC: begin
               if (stop)
                  state <= HS_IDLE;
            end
            default: ;
         endcase
      end
   end

   assign clr_we   = (state == HS_CLEAR);
   assign acc_fire = (state == HS_ACC) && in_valid && in_range && !start;

   // R2
   clr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we && $past(clr_we) && !$past(start) |-> clr_addr == $past(clr_addr) + 1'b1);

endmodule

// File: rtl/adc_hist_bins.sv
module adc_hist_bins #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 2 ** ADDR_W;

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         store[waddr] <= wdata;
      rdata <= store[raddr];
   end

endmodule

// File: rtl/adc_hist_incr.sv
module adc_hist_incr #(
   parameter int CODE_W   = 10,
   parameter int CNT_W    = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              fire,
   input  logic [CODE_W-1:0] addr,
   input  logic [CNT_W-1:0]  mem_q,
   output logic              wr_en,
   output logic [CODE_W-1:0] wr_addr,
   output logic [CNT_W-1:0]  wr_data
);

   logic              s1_v;
   logic [CODE_W-1:0] s1_a;
   logic              fw_v;
   logic [CODE_W-1:0] fw_a;
   logic [CNT_W-1:0]  fw_d;
   logic [CNT_W-1:0]  base;
   logic [CNT_W-1:0]  nxt;

   // the memory read issued with the previous write returns the stale value
   assign base = (fw_v && fw_a == s1_a) ? fw_d : mem_q;

   generate
      if (SATURATE) begin : g_sat
         assign nxt = (&base) ? base : base + 1'b1;

         // R7
         sat_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |-> wr_data != '0);

         // R6
         same_bin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && $past(wr_en) && !$past(flush) && wr_addr == $past(wr_addr)
            |-> (wr_data == $past(wr_data) + 1'b1) || (&wr_data));
      end else begin : g_wrap
         assign nxt = base + 1'b1;
      end
   endgenerate

   assign wr_en   = s1_v && !flush;
   assign wr_addr = s1_a;
   assign wr_data = nxt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v <= 1'b0;
         s1_a <= '0;
         fw_v <= 1'b0;
         fw_a <= '0;
         fw_d <= '0;
      end else begin
         s1_v <= fire && !flush;
         s1_a <= addr;
         fw_v <= wr_en;
         fw_a <= s1_a;
         fw_d <= nxt;
      end
   end

endmodule

// File: rtl/adc_hist_collector.sv
module adc_hist_collector
   import adc_hist_pkg::*;
#(
   parameter int CODE_W   = 10,
   parameter int SAMPLE_W = 16,
   parameter int CNT_W    = 32,
   parameter int TOT_W    = 32,
   parameter int WARM_W   = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                stop,
   input  logic [WARM_W-1:0]   warm_cnt,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_code,
   output logic                busy,
   output logic                accum,
   output logic [TOT_W-1:0]    total,
   input  logic                rd_en,
   input  logic [CODE_W-1:0]   rd_addr,
   output logic                rd_valid,
   output logic [CNT_W-1:0]    rd_data
);

   localparam int NBINS = 2 ** CODE_W;
   localparam logic [SAMPLE_W-1:0] MAX_CODE = SAMPLE_W'(NBINS - 1);

   generate
      if (CODE_W < 2 || CODE_W > 16) begin : g_bad_code
         $error("CODE_W must lie in 2..16");
      end
      if (SAMPLE_W < CODE_W) begin : g_bad_sample
         $error("SAMPLE_W must be at least CODE_W");
      end
      if (CNT_W < 2 || TOT_W < 2 || WARM_W < 1) begin : g_bad_cnt
         $error("counter widths too small");
      end
   endgenerate

   hist_state_e       state;
   logic              in_range;
   logic              clr_we;
   logic [CODE_W-1:0] clr_addr;
   logic              acc_fire;
   logic              inc_we;
   logic [CODE_W-1:0] inc_addr;
   logic [CNT_W-1:0]  inc_data;
   logic              m_we;
   logic [CODE_W-1:0] m_waddr;
   logic [CNT_W-1:0]  m_wdata;
   logic [CODE_W-1:0] m_raddr;
   logic              idle;
   logic              rd_ok;

   assign in_range = (in_code <= MAX_CODE);

   adc_hist_ctrl #(.CODE_W(CODE_W), .WARM_W(WARM_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .stop     (stop),
      .warm_cnt (warm_cnt),
      .in_valid (in_valid),
      .in_range (in_range),
      .state    (state),
      .clr_we   (clr_we),
      .clr_addr (clr_addr),
      .acc_fire (acc_fire)
   );

   adc_hist_incr #(.CODE_W(CODE_W), .CNT_W(CNT_W), .SATURATE(SATURATE)) u_incr (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (clr_we),
      .fire    (acc_fire),
      .addr    (in_code[CODE_W-1:0]),
      .mem_q   (rd_data),
      .wr_en   (inc_we),
      .wr_addr (inc_addr),
      .wr_data (inc_data)
   );

   assign idle    = (state == HS_IDLE);
   assign rd_ok   = rd_en && idle && !inc_we && !start;
   assign m_we    = clr_we | inc_we;
   assign m_waddr = clr_we ? clr_addr : inc_addr;
   assign m_wdata = clr_we ? '0 : inc_data;
   assign m_raddr = idle ? rd_addr : in_code[CODE_W-1:0];

   adc_hist_bins #(.ADDR_W(CODE_W), .DATA_W(CNT_W)) u_bins (
      .clk   (clk),
      .we    (m_we),
      .waddr (m_waddr),
      .wdata (m_wdata),
      .raddr (m_raddr),
      .rdata (rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         total    <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_ok;
         if (clr_we)
            total <= '0;
         else if (acc_fire && !(&total))
            total <= total + 1'b1;
      end
   end

   assign busy  = clr_we;
   assign accum = (state == HS_ACC);

   // R8
   total_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (total == $past(total)) || (total == $past(total) + 1'b1));

   // R5
   oor_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (in_code > MAX_CODE) && !busy |=> $stable(total));

   // R9
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !busy && !accum);

endmodule

// File: tb/tb_adc_hist_collector.sv
`timescale 1ns/1ps
module tb_adc_hist_collector;

   localparam int CODE_W   = 4;
   localparam int SAMPLE_W = 6;
   localparam int CNT_W    = 4;
   localparam int TOT_W    = 8;
   localparam int WARM_W   = 4;
   localparam int NB       = 2 ** CODE_W;
   localparam int CMAX     = 2 ** CNT_W - 1;
   localparam int TMAX     = 2 ** TOT_W - 1;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                start = 1'b0;
   logic                stop = 1'b0;
   logic [WARM_W-1:0]   warm_cnt = '0;
   logic                in_valid = 1'b0;
   logic [SAMPLE_W-1:0] in_code = '0;
   logic                busy, accum, rd_valid;
   logic [TOT_W-1:0]    total;
   logic                rd_en = 1'b0;
   logic [CODE_W-1:0]   rd_addr = '0;
   logic [CNT_W-1:0]    rd_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   int exp_bin [NB];
   int exp_tot;
   int warm_rem;
   bit acc_on;

   always #4 clk = ~clk;

   adc_hist_collector #(
      .CODE_W(CODE_W), .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W),
      .TOT_W(TOT_W), .WARM_W(WARM_W), .SATURATE(1'b1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .warm_cnt(warm_cnt),
      .in_valid(in_valid), .in_code(in_code), .busy(busy), .accum(accum),
      .total(total), .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
      .rd_data(rd_data)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < NB; i++) exp_bin[i] = 0;
      exp_tot = 0;
   endtask

   // start pulse; samples are driven during the whole clear (R11)
   task automatic run_start(input int w);
      int n;
      @(negedge clk);
      start = 1'b1;
      warm_cnt = WARM_W'(w);
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (busy) begin
         n++;
         in_valid = 1'b1;
         in_code  = SAMPLE_W'(9);
         @(negedge clk);
      end
      in_valid = 1'b0;
      check("R2 clear length", n, NB);
      model_clear();
      warm_rem = w;
      acc_on = 1'b1;
   endtask

   task automatic drive(input int code);
      @(negedge clk);
      in_valid = 1'b1;
      in_code  = SAMPLE_W'(code);
      @(posedge clk);
      if (acc_on) begin
         if (warm_rem > 0) warm_rem--;
         else if (code < NB) begin
            if (exp_bin[code] < CMAX) exp_bin[code]++;
            if (exp_tot < TMAX) exp_tot++;
         end
      end
   endtask

   task automatic idle_cyc(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   task automatic do_stop();
      @(negedge clk);
      in_valid = 1'b0;
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      acc_on = 1'b0;
   endtask

   task automatic read_all(input string req);
      for (int a = 0; a < NB; a++) begin
         @(negedge clk);
         rd_en = 1'b1;
         rd_addr = CODE_W'(a);
         @(negedge clk);
         rd_en = 1'b0;
         check({req, " rd_valid"}, int'(rd_valid), 1);
         check(req, int'(rd_data), exp_bin[a]);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      acc_on = 1'b0;
      warm_rem = 0;
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check("R1 busy", int'(busy), 0);
      check("R1 accum", int'(accum), 0);
      check("R1 total", int'(total), 0);
      check("R1 rd_valid", int'(rd_valid), 0);

      // run 1: warm-up of 3, then sweep of all codes
      run_start(3);
      check("R2 total after clear", int'(total), 0);
      check("R3 accum low during warm-up", int'(accum), 0);
      drive(5); drive(5);
      idle_cyc(1);
      check("R3 still warming", int'(accum), 0);
      drive(60);
      idle_cyc(1);
      check("R3 accum after warm-up", int'(accum), 1);
      check("R3 warm-up discarded", int'(total), 0);
      for (int c = 0; c < 2 ** SAMPLE_W; c++) drive(c);   // R4 R5
      idle_cyc(1);
      check("R5 R8 total after sweep", int'(total), exp_tot);
      for (int k = 0; k < 20; k++) drive(7);               // R6 R7 burst
      drive(3); drive(3); drive(4); drive(3);
      idle_cyc(1);
      drive(3); drive(40); drive(3); drive(12);
      idle_cyc(1);
      // R9 read while accumulating is refused
      @(negedge clk);
      rd_en = 1'b1;
      rd_addr = CODE_W'(3);
      @(negedge clk);
      rd_en = 1'b0;
      check("R9 no read while accumulating", int'(rd_valid), 0);
      check("R8 total", int'(total), exp_tot);
      do_stop();
      check("R10 accum low after stop", int'(accum), 0);
      drive(1); drive(1); drive(2);                        // R10 ignored
      idle_cyc(2);
      check("R10 total frozen", int'(total), exp_tot);
      check("R7 saturated bin model", exp_bin[7], CMAX);
      read_all("R4 R6 R7 R10 bin");

      // run 2: clear only, check every bin is zero
      run_start(0);
      do_stop();
      idle_cyc(1);
      check("R2 total zero", int'(total), 0);
      read_all("R2 R11 cleared bin");

      // run 3: no warm-up, long single-bin stream
      run_start(0);
      check("R3 zero warm-up accum", int'(accum), 1);
      for (int k = 0; k < 300; k++) drive(2);
      drive(15); drive(0);
      idle_cyc(1);
      check("R8 total saturates", int'(total), TMAX);
      do_stop();
      idle_cyc(1);
      read_all("R7 R8 bin");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule